// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Shadowed Reload

This block generates four independent pulse-width-modulated outputs from one clock. Software programs it through a simple 32-bit register bus: a write strobe, a read strobe, an 8-bit byte address and 32-bit write and read data. Each channel has a period count and a low-time count. Each period begins with a high phase of (period − low-time) clocks and ends with a low phase of low-time clocks.

Values written to the count registers are only stored in the register file. A channel copies them into private working registers when its run bit rises, or when its reload bit rises while it runs. Software can therefore rewrite both counts of a live channel and commit them together with one 1-then-0 pulse on the reload bit, so no cycle ever mixes old and new counts. A channel drives its output low whenever its run bit or its drive-enable bit is clear.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every output is low and every register reads 0.
- R2: The registers read back the last value written. Channel n has low-time at byte address 8·n and period at 8·n+4 (30 bits each). The mode bits are at 0x40, run at 0x44, reload at 0x4C and drive-enable at 0xD0, with bit n belonging to channel n. Address 0x48 always reads 0, including after a write to it.
- R3: If the write that sets run bit n lands on clock edge E0, the working counts load at E1. From E1 the output is high for (period − low) clocks, then low for low clocks, and this repeats every period clocks.
- R4: While a channel runs, writes to its counts do not change its output. A write that sets its reload bit at edge E0 reloads the counts and restarts the cycle at E1, exactly as in R3.
- R5: A channel whose run bit or drive-enable bit is 0 outputs low, from the edge that clears the bit onwards.
- R6: A low-time of 0 holds the output high for the whole period.
- R7: A low-time greater than or equal to the period holds the output low.
- R8: With period 2 and low-time 1, the output toggles every clock, which is the clock divided by 2.
- R9: A rising reload bit on a stopped channel has no effect, and its output stays low. A later start uses the registers' current values.
- R10: The mode register at 0x40 is stored and read back, but it does not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe; a write happens at the rising clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when bus_rd is low |
| pwm_out | output | 4 | One output per channel |

## Verification
A wrong working count or a missed load shows on the channel pin within one period. Either the high-phase length or the wrap point moves, and the bench compares every clock of several periods against its own model. A load on the wrong event, such as a reload seen on a stopped channel or a load with no rising edge, shows as a pin that leaves its expected phase on the clock after the event. A gating fault shows on the first clock after the run or drive-enable bit is cleared.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int unsigned DW = 32;
  localparam logic [7:0] OFS_MODE  = 8'h40;
  localparam logic [7:0] OFS_RUN   = 8'h44;
  localparam logic [7:0] OFS_STAT  = 8'h48;
  localparam logic [7:0] OFS_RELD  = 8'h4C;
  localparam logic [7:0] OFS_DRIVE = 8'hD0;

  // clocks per period spent high; zero when the low phase covers the period
  function automatic logic [31:0] high_len(input logic [31:0] per,
                                           input logic [31:0] low);
    return (low >= per) ? 32'd0 : per - low;
  endfunction

  // counter successor; wraps at per-1, stuck at 0 for degenerate periods
  function automatic logic [31:0] next_count(input logic [31:0] cnt,
                                             input logic [31:0] per);
    if (per < 32'd2 || cnt >= per - 32'd1) return 32'd0;
    return cnt + 32'd1;
  endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned PW  = 30,
  parameter int unsigned AW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic [NCH-1:0][PW-1:0]  low_q,
  output logic [NCH-1:0][PW-1:0]  per_q,
  output logic [NCH-1:0]          run_q,
  output logic [NCH-1:0]          reld_q,
  output logic [NCH-1:0]          drive_q
);
  logic [NCH-1:0] mode_q;
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DW-1:PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      per_q   <= '0;
      run_q   <= '0;
      reld_q  <= '0;
      drive_q <= '0;
      mode_q  <= '0;
    end else if (wr_en) begin
      for (int n = 0; n < NCH; n++) begin
        if (addr == AW'(8 * n))     low_q[n] <= wdata[PW-1:0];
        if (addr == AW'(8 * n + 4)) per_q[n] <= wdata[PW-1:0];
      end
      if (addr == AW'(OFS_MODE))  mode_q  <= wdata[NCH-1:0];
      if (addr == AW'(OFS_RUN))   run_q   <= wdata[NCH-1:0];
      if (addr == AW'(OFS_RELD))  reld_q  <= wdata[NCH-1:0];
      if (addr == AW'(OFS_DRIVE)) drive_q <= wdata[NCH-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int n = 0; n < NCH; n++) begin
        if (addr == AW'(8 * n))     rdata = DW'(low_q[n]);
        if (addr == AW'(8 * n + 4)) rdata = DW'(per_q[n]);
      end
      if (addr == AW'(OFS_MODE))  rdata = DW'(mode_q);
      if (addr == AW'(OFS_RUN))   rdata = DW'(run_q);
      if (addr == AW'(OFS_RELD))  rdata = DW'(reld_q);
      if (addr == AW'(OFS_DRIVE)) rdata = DW'(drive_q);
      if (addr == AW'(OFS_STAT))  rdata = '0;
    end
  end
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
  import pwm_quad_pkg::*;
#(
  parameter int unsigned PW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          reld,
  input  logic          drive,
  input  logic [PW-1:0] per_in,
  input  logic [PW-1:0] low_in,
  output logic          load_o,
  output logic          pwm_o
);
  logic          run_d, reld_d, live;
  logic [PW-1:0] per_w, low_w, cnt;
  logic [31:0]   hi_w, cnt_nx;

  // load on a rising run bit, or on a rising reload bit while running
  assign load_o = run & (~run_d | (reld & ~reld_d));
  assign hi_w   = high_len(32'(per_w), 32'(low_w));
  assign cnt_nx = next_count(32'(cnt), 32'(per_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d  <= 1'b0;
      reld_d <= 1'b0;
      live   <= 1'b0;
      per_w  <= '0;
      low_w  <= '0;
      cnt    <= '0;
    end else begin
      run_d  <= run;
      reld_d <= reld;
      if (load_o) begin
        per_w <= per_in;
        low_w <= low_in;
        cnt   <= '0;
        live  <= 1'b1;
      end else if (!run) begin
        live  <= 1'b0;
      end else if (live) begin
        cnt   <= cnt_nx[PW-1:0];
      end
    end
  end

  assign pwm_o = live & run & drive & (32'(cnt) < hi_w);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned PW  = 30,
  parameter int unsigned AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);
  logic [NCH-1:0][PW-1:0] low_q, per_q;
  logic [NCH-1:0]         run_bits, reld_bits, drive_bits;
  logic [NCH-1:0]         ld_evt;

  pwm_quad_regs #(.NCH(NCH), .PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .low_q(low_q), .per_q(per_q), .run_q(run_bits),
    .reld_q(reld_bits), .drive_q(drive_bits)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm_quad_chan #(.PW(PW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .run(run_bits[n]), .reld(reld_bits[n]), .drive(drive_bits[n]),
      .per_in(per_q[n]), .low_in(low_q[n]),
      .load_o(ld_evt[n]), .pwm_o(pwm_out[n])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] run_bits,
  input logic [NCH-1:0] drive_bits,
  input logic [NCH-1:0] ld_evt,
  input logic [NCH-1:0] pwm_out
);
  p_gate_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_out & ~(run_bits & drive_bits)) == '0);

  p_load_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_evt & ~run_bits) == '0);

  p_stat_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(8'h48)) |-> bus_rdata == 32'd0);

  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pwm_out == '0);

  for (genvar n = 0; n < NCH; n++) begin : g_p
    p_no_early_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_bits[n]) |-> !pwm_out[n]);
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .run_bits(run_bits), .drive_bits(drive_bits),
  .ld_evt(ld_evt), .pwm_out(pwm_out)
);

// File: tb/sim_pwm_quad.sv
`timescale 1ns/1ps
module sim_pwm_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  pwm_quad u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
               .bus_addr(bus_addr), .bus_wdata(bus_wdata),
               .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1; #1;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  // sample k (k>=1) is taken after the k-th edge following the loading write
  task automatic wave(input int ch, input int per, input int low, input int k0,
                      input int n, input string req);
    int hi;
    hi = (low >= per) ? 0 : per - low;
    for (int i = 0; i < n; i++) begin
      int k;
      k = k0 + i;
      @(posedge clk); @(negedge clk);
      chk(pwm_out[ch] == (((k - 1) % per) < hi), req, pwm_out[ch], ((k - 1) % per) < hi);
    end
  endtask

  task automatic stay_low(input int ch, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(pwm_out[ch] == 1'b0, req, pwm_out[ch], 0);
    end
  endtask

  task automatic t_reset();
    chk(pwm_out == 4'h0, "R1 outputs", pwm_out, 0);
    for (int n = 0; n < 4; n++) begin
      rd_chk(8'(8 * n), 0, "R1 low reg");
      rd_chk(8'(8 * n + 4), 0, "R1 period reg");
    end
    rd_chk(8'h40, 0, "R1 mode"); rd_chk(8'h44, 0, "R1 run");
    rd_chk(8'h4C, 0, "R1 reload"); rd_chk(8'hD0, 0, "R1 drive");
  endtask

  task automatic t_readback();
    wr(8'h00, 3); wr(8'h04, 10); wr(8'h1C, 32'h3FFF_FFFF); wr(8'h40, 32'hA);
    wr(8'h48, 32'hF);
    rd_chk(8'h00, 3, "R2 low0"); rd_chk(8'h04, 10, "R2 per0");
    rd_chk(8'h1C, 32'h3FFF_FFFF, "R2 per3"); rd_chk(8'h40, 32'hA, "R2 mode");
    rd_chk(8'h48, 0, "R2 status zero");
    wr(8'h40, 0); wr(8'h1C, 0);
  endtask

  task automatic t_start_and_shadow();
    wr(8'hD0, 32'hF);
    wr(8'h44, 32'h1);
    wave(0, 10, 3, 1, 25, "R3 first run");
    wr(8'h04, 6); wr(8'h00, 2);
    wave(0, 10, 3, 28, 15, "R4 shadow held");
    wr(8'h4C, 32'h1);
    wave(0, 6, 2, 1, 18, "R4 reload");
    wr(8'h4C, 32'h0);
    wave(0, 6, 2, 20, 6, "R4 reload clear");
  endtask

  task automatic t_gate();
    wr(8'hD0, 32'h0);
    stay_low(0, 8, "R5 drive off");
    wr(8'hD0, 32'hF);
    wr(8'h44, 32'h0);
    stay_low(0, 8, "R5 stopped");
  endtask

  task automatic t_full();
    wr(8'h08, 0); wr(8'h0C, 7);
    wr(8'h44, 32'h2);
    wave(1, 7, 0, 1, 20, "R6 full high");
  endtask

  task automatic t_over();
    wr(8'h10, 9); wr(8'h14, 5);
    wr(8'h44, 32'h6);
    wave(2, 5, 9, 1, 12, "R7 low over period");
  endtask

  task automatic t_fast();
    wr(8'h18, 1); wr(8'h1C, 2);
    wr(8'h44, 32'hE);
    wave(3, 2, 1, 1, 10, "R8 divide by two");
  endtask

  task automatic t_idle_reload();
    wr(8'h44, 32'h0);
    wr(8'h00, 1); wr(8'h04, 4);
    wr(8'h4C, 32'h1);
    stay_low(0, 6, "R9 reload while stopped");
    wr(8'h4C, 32'h0);
    wr(8'h44, 32'h1);
    wave(0, 4, 1, 1, 8, "R9 start after idle reload");
    wr(8'h40, 32'hF);
    wave(0, 4, 1, 10, 8, "R10 mode ignored");
    rd_chk(8'h40, 32'hF, "R10 mode readback");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_start_and_shadow();
    t_gate();
    t_full();
    t_over();
    t_fast();
    t_idle_reload();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule